// File: doc/BRIEF.md
# Response Ring Interrupt Coalescer

This block decides when a response ring should interrupt its consumer. It watches the ring's occupancy and the pulses that mark entries arriving and being consumed. It raises a count event when more entries are waiting than a programmed threshold. It raises a timeout event when the oldest outstanding work has waited for a programmed holdoff period. The holdoff is counted in coarse ticks of a fixed number of clock cycles, so a small register can cover long delays.

Both events land in sticky status bits that software clears by writing ones. A per-bit enable mask selects which status bits drive the single interrupt line. Both configuration values are clamped as they are written, so the stored state is always legal for the ring depth. The ring depth is 4 or 8 entries, and the default threshold is one less than that depth.

Top module: `ring_irq_coalesce`

## Requirements
- R1: After reset the status bits are 0, the interrupt is low, the stored threshold equals ring entries minus 1 (7 for an 8-entry ring) and the stored holdoff is 0.
- R2: A threshold write of a value at or above the ring entry count stores ring entries minus 1. A smaller value is stored unchanged and can be read back on the next cycle.
- R3: A holdoff write larger than 4096 stores 4096. Any other value is stored unchanged.
- R4: Status bit 0 (count event) is set on the clock edge where occupancy is strictly greater than the stored threshold. It is not set when occupancy equals the threshold.
- R5: An arrival pulse while the timer is idle and the holdoff is non-zero starts the timer. Status bit 1 (timeout event) becomes set exactly holdoff × 256 clock edges after the edge that took the arrival, provided the ring is still non-empty. This happens even when occupancy is below the threshold.
- R6: If occupancy drops to 0 before the timer expires, and no arrival comes in that cycle, the timer is abandoned and status bit 1 is not set.
- R7: A stored holdoff of 0 turns off the timeout path, so status bit 1 is never set.
- R8: Status bits are sticky. Writing a 1 in the clear mask clears the matching bit, and a 0 leaves it alone. If a set condition and a clear occur in the same cycle, the set wins.
- R9: The interrupt output is high exactly when some status bit is set and its enable bit is set. Enable bit 0 gates the count event and enable bit 1 gates the timeout event.
- R10: An arrival pulse while the timer is running does not restart it. A consumption pulse while the ring stays non-empty restarts the full holdoff period from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| occupancy | input | OCC_W (4) | Current number of entries held in the ring |
| arrive_pulse | input | 1 | One-cycle pulse when an entry is written to the ring |
| consume_pulse | input | 1 | One-cycle pulse when the consumer retires an entry |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | CFG_W (8) | Requested threshold |
| hold_we | input | 1 | Holdoff write strobe |
| hold_wdata | input | HOLD_IN_W (16) | Requested holdoff, in 256-cycle ticks |
| irq_en_we | input | 1 | Enable mask write strobe |
| irq_en_wdata | input | 2 | Enable mask (bit 0 count, bit 1 timeout) |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 2 | Write-one-to-clear mask for the status bits |
| thr_value | output | THR_W (3) | Stored, clamped threshold |
| hold_value | output | HOLD_W (13) | Stored, saturated holdoff |
| irq_status | output | 2 | Sticky status (bit 0 count event, bit 1 timeout event) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong tick or cycle count in the holdoff timer shows up as status bit 1 rising one or more edges early or late. The bench probes the edge just before the expected expiry and the edge of the expiry itself. A timer that missed a restart or an abandon decision shows up as a timeout hundreds of cycles away from the expected point, or where none should occur. A mis-clamped configuration register is visible on its readback port on the cycle after the write. A broken comparison or clear shows up in the status bits one edge after the stimulus.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;

  localparam int ST_BITS = 2;
  localparam int ST_CNT  = 0;
  localparam int ST_TMO  = 1;

  // Threshold legal range is 0 .. entries-1.
  function automatic int unsigned clamp_threshold(input int unsigned req,
                                                  input int unsigned entries);
    return (req >= entries) ? entries - 1 : req;
  endfunction

  // Holdoff saturates at the tick limit.
  function automatic int unsigned clamp_holdoff(input int unsigned req,
                                                input int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

  // Count event: strictly more entries waiting than the threshold.
  function automatic logic occupancy_exceeds(input int unsigned occ,
                                             input int unsigned thr);
    return occ > thr;
  endfunction

  // True when the tick count that will be reached at this wrap meets the holdoff.
  function automatic logic holdoff_reached(input int unsigned ticks_done,
                                           input int unsigned hold);
    return (ticks_done + 1) >= hold;
  endfunction

endpackage

// File: rtl/ring_irq_cfg.sv
module ring_irq_cfg
  import ring_irq_pkg::*;
#(
  parameter int RING_ENTRIES = 8,
  parameter int HOLD_LIMIT   = 4096,
  parameter int HOLD_RESET   = 0,
  parameter int CFG_W        = 8,
  parameter int HOLD_IN_W    = 16,
  localparam int THR_W       = $clog2(RING_ENTRIES),
  localparam int HOLD_W      = $clog2(HOLD_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 thr_we,
  input  logic [CFG_W-1:0]     thr_din,
  input  logic                 hold_we,
  input  logic [HOLD_IN_W-1:0] hold_din,
  output logic [THR_W-1:0]     thr_q,
  output logic [HOLD_W-1:0]    hold_q
);

  logic [THR_W-1:0]  thr_next;
  logic [HOLD_W-1:0] hold_next;

  always_comb begin
    thr_next  = THR_W'(clamp_threshold(32'(thr_din), RING_ENTRIES));
    hold_next = HOLD_W'(clamp_holdoff(32'(hold_din), HOLD_LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= THR_W'(RING_ENTRIES - 1);
      hold_q <= HOLD_W'(clamp_holdoff(HOLD_RESET, HOLD_LIMIT));
    end else begin
      if (thr_we)  thr_q  <= thr_next;
      if (hold_we) hold_q <= hold_next;
    end
  end

  p_thr_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_we && (32'(thr_din) >= RING_ENTRIES)) |=> (32'(thr_q) == RING_ENTRIES - 1));

  p_hold_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_we && (32'(hold_din) > HOLD_LIMIT)) |=> (32'(hold_q) == HOLD_LIMIT));

endmodule

// File: rtl/ring_irq_holdoff.sv
module ring_irq_holdoff
  import ring_irq_pkg::*;
#(
  parameter int TICK_CYCLES = 256,
  parameter int HOLD_LIMIT  = 4096,
  parameter int OCC_W       = 4,
  localparam int PRE_W      = $clog2(TICK_CYCLES),
  localparam int HOLD_W     = $clog2(HOLD_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_q,
  input  logic [OCC_W-1:0]  occ,
  input  logic              arrive,
  input  logic              consume,
  output logic              expire
);

  logic              running;
  logic [PRE_W-1:0]  pre_cnt;
  logic [HOLD_W-1:0] tick_cnt;

  // Named internal events.
  logic ring_empty, armed, start_w, stop_w, restart_w, wrap_w, expire_w;

  always_comb begin
    ring_empty = (occ == '0);
    armed      = (hold_q != '0);
    start_w    = arrive && !running && armed;
    stop_w     = running && ((ring_empty && !arrive) || !armed);
    restart_w  = running && !stop_w && consume && !ring_empty;
    wrap_w     = running && (pre_cnt == PRE_W'(TICK_CYCLES - 1));
    expire_w   = wrap_w && !stop_w && !restart_w &&
                 holdoff_reached(32'(tick_cnt), 32'(hold_q));
  end

  assign expire = expire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (start_w) begin
      running  <= 1'b1;
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (stop_w || expire_w) begin
      running  <= 1'b0;
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (restart_w) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (running) begin
      if (wrap_w) begin
        pre_cnt  <= '0;
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        pre_cnt  <= pre_cnt + 1'b1;
      end
    end
  end

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q == '0) |=> !running);

  p_empty_abandon_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ring_empty && !arrive) |=> !running);

  p_restart_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && consume && !ring_empty && armed) |=> !expire_w);

  p_expire_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (occ != '0));

endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status
  import ring_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ST_BITS-1:0] set_vec,
  input  logic               clr_we,
  input  logic [ST_BITS-1:0] clr_mask,
  input  logic               en_we,
  input  logic [ST_BITS-1:0] en_din,
  output logic [ST_BITS-1:0] status,
  output logic               irq
);

  logic [ST_BITS-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_din;
  end

  for (genvar i = 0; i < ST_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      status[i] <= 1'b0;
      else if (set_vec[i])             status[i] <= 1'b1;
      else if (clr_we && clr_mask[i])  status[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status[i]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !set_vec[i]) |=> !status[i]);
  end

  assign irq = |(status & en_q);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: rtl/ring_irq_coalesce.sv
module ring_irq_coalesce
  import ring_irq_pkg::*;
#(
  parameter int RING_ENTRIES = 8,
  parameter int TICK_CYCLES  = 256,
  parameter int HOLD_LIMIT   = 4096,
  parameter int HOLD_RESET   = 0,
  parameter int CFG_W        = 8,
  parameter int HOLD_IN_W    = 16,
  localparam int OCC_W       = $clog2(RING_ENTRIES + 1),
  localparam int THR_W       = $clog2(RING_ENTRIES),
  localparam int HOLD_W      = $clog2(HOLD_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OCC_W-1:0]     occupancy,
  input  logic                 arrive_pulse,
  input  logic                 consume_pulse,
  input  logic                 thr_we,
  input  logic [CFG_W-1:0]     thr_wdata,
  input  logic                 hold_we,
  input  logic [HOLD_IN_W-1:0] hold_wdata,
  input  logic                 irq_en_we,
  input  logic [1:0]           irq_en_wdata,
  input  logic                 stat_clr_we,
  input  logic [1:0]           stat_clr_mask,
  output logic [THR_W-1:0]     thr_value,
  output logic [HOLD_W-1:0]    hold_value,
  output logic [1:0]           irq_status,
  output logic                 irq
);

  logic               count_event;
  logic               timeout_event;
  logic [ST_BITS-1:0] set_vec;

  ring_irq_cfg #(
    .RING_ENTRIES(RING_ENTRIES),
    .HOLD_LIMIT  (HOLD_LIMIT),
    .HOLD_RESET  (HOLD_RESET),
    .CFG_W       (CFG_W),
    .HOLD_IN_W   (HOLD_IN_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .thr_we  (thr_we),
    .thr_din (thr_wdata),
    .hold_we (hold_we),
    .hold_din(hold_wdata),
    .thr_q   (thr_value),
    .hold_q  (hold_value)
  );

  ring_irq_holdoff #(
    .TICK_CYCLES(TICK_CYCLES),
    .HOLD_LIMIT (HOLD_LIMIT),
    .OCC_W      (OCC_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_q (hold_value),
    .occ    (occupancy),
    .arrive (arrive_pulse),
    .consume(consume_pulse),
    .expire (timeout_event)
  );

  always_comb begin
    count_event     = occupancy_exceeds(32'(occupancy), 32'(thr_value));
    set_vec         = '0;
    set_vec[ST_CNT] = count_event;
    set_vec[ST_TMO] = timeout_event;
  end

  ring_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (stat_clr_we),
    .clr_mask(stat_clr_mask),
    .en_we   (irq_en_we),
    .en_din  (irq_en_wdata),
    .status  (irq_status),
    .irq     (irq)
  );

  p_count_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occupancy) > 32'(thr_value)) |=> irq_status[0]);

  p_thr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(thr_value) < RING_ENTRIES);

endmodule

// File: tb/ring_irq_coalesce_bench.sv
`timescale 1ns/1ps
module ring_irq_coalesce_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  occupancy;
  logic        arrive_pulse, consume_pulse;
  logic        thr_we, hold_we, irq_en_we, stat_clr_we;
  logic [7:0]  thr_wdata;
  logic [15:0] hold_wdata;
  logic [1:0]  irq_en_wdata, stat_clr_mask;
  logic [2:0]  thr_value;
  logic [12:0] hold_value;
  logic [1:0]  irq_status;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  ring_irq_coalesce u_ring_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy),
    .arrive_pulse(arrive_pulse), .consume_pulse(consume_pulse),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .hold_we(hold_we), .hold_wdata(hold_wdata),
    .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
    .thr_value(thr_value), .hold_value(hold_value),
    .irq_status(irq_status), .irq(irq)
  );

  // {threshold[15:8], occupancy[7:4], expected count bit[0]}
  localparam logic [15:0] CNT_VEC [9] = '{
    {8'd7, 4'd8, 4'd1}, {8'd7, 4'd7, 4'd0}, {8'd3, 4'd4, 4'd1},
    {8'd3, 4'd3, 4'd0}, {8'd0, 4'd1, 4'd1}, {8'd0, 4'd0, 4'd0},
    {8'd5, 4'd6, 4'd1}, {8'd2, 4'd8, 4'd1}, {8'd6, 4'd2, 4'd0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_thr(input int v);
    thr_we = 1'b1; thr_wdata = 8'(v); step(1); thr_we = 1'b0;
  endtask

  task automatic wr_hold(input int v);
    hold_we = 1'b1; hold_wdata = 16'(v); step(1); hold_we = 1'b0;
  endtask

  task automatic wr_en(input logic [1:0] v);
    irq_en_we = 1'b1; irq_en_wdata = v; step(1); irq_en_we = 1'b0;
  endtask

  task automatic clr(input logic [1:0] m);
    stat_clr_we = 1'b1; stat_clr_mask = m; step(1); stat_clr_we = 1'b0;
  endtask

  task automatic idle_ring();
    occupancy = 4'd0; step(1); clr(2'b11);
  endtask

  // Arrival with one entry at negedge #0; returns at negedge #1.
  task automatic start_timer();
    arrive_pulse = 1'b1; occupancy = 4'd1; step(1); arrive_pulse = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; occupancy = '0; arrive_pulse = 0; consume_pulse = 0;
    thr_we = 0; hold_we = 0; irq_en_we = 0; stat_clr_we = 0;
    thr_wdata = '0; hold_wdata = '0; irq_en_wdata = '0; stat_clr_mask = '0;
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    chk("R1 status", irq_status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 threshold", thr_value, 7);
    chk("R1 holdoff", hold_value, 0);

    // R4 table walk
    foreach (CNT_VEC[i]) begin
      thr_we = 1'b1; thr_wdata = CNT_VEC[i][15:8];
      occupancy = 4'd0; stat_clr_we = 1'b1; stat_clr_mask = 2'b11;
      step(1);
      thr_we = 1'b0; stat_clr_we = 1'b0; occupancy = CNT_VEC[i][7:4];
      step(1);
      chk("R4 count event", irq_status[0], int'(CNT_VEC[i][0]));
    end
    idle_ring();

    // R2 threshold clamp
    wr_thr(8);   chk("R2 clamp 8", thr_value, 7);
    wr_thr(200); chk("R2 clamp 200", thr_value, 7);
    wr_thr(3);   chk("R2 keep 3", thr_value, 3);
    wr_thr(0);   chk("R2 keep 0", thr_value, 0);
    wr_thr(7);   chk("R2 keep 7", thr_value, 7);

    // R3 holdoff saturation
    wr_hold(5000);  chk("R3 sat 5000", hold_value, 4096);
    wr_hold(65535); chk("R3 sat 65535", hold_value, 4096);
    wr_hold(4096);  chk("R3 keep 4096", hold_value, 4096);
    wr_hold(1);     chk("R3 keep 1", hold_value, 1);

    // R5 expiry at holdoff*256 edges, below threshold
    idle_ring();
    start_timer(); step(255);
    chk("R5 before expiry", irq_status[1], 0);
    step(1);
    chk("R5 at expiry", irq_status[1], 1);
    chk("R5 count bit idle", irq_status[0], 0);
    idle_ring();

    // R5 with holdoff of 2 ticks
    wr_hold(2);
    start_timer(); step(511);
    chk("R5 2-tick before", irq_status[1], 0);
    step(1);
    chk("R5 2-tick at", irq_status[1], 1);
    idle_ring();
    wr_hold(1);

    // R10 arrival while running does not restart
    start_timer(); step(99);
    arrive_pulse = 1'b1; occupancy = 4'd2; step(1); arrive_pulse = 1'b0;
    step(155);
    chk("R10 arrival before", irq_status[1], 0);
    step(1);
    chk("R10 arrival no restart", irq_status[1], 1);
    idle_ring();

    // R10 consumption restarts the holdoff
    occupancy = 4'd0; step(1);
    arrive_pulse = 1'b1; occupancy = 4'd2; step(1); arrive_pulse = 1'b0;
    step(99);
    consume_pulse = 1'b1; occupancy = 4'd1; step(1); consume_pulse = 1'b0;
    step(155);
    chk("R10 no original expiry", irq_status[1], 0);
    step(100);
    chk("R10 restart before", irq_status[1], 0);
    step(1);
    chk("R10 restart expiry", irq_status[1], 1);
    idle_ring();

    // R6 ring drains before expiry
    start_timer(); step(49);
    occupancy = 4'd0; step(250);
    chk("R6 abandoned", irq_status[1], 0);
    idle_ring();

    // R7 holdoff 0 disables timeout
    wr_hold(0);
    start_timer(); step(1100);
    chk("R7 disabled", irq_status[1], 0);
    idle_ring();

    // R8 sticky and write-one-to-clear
    wr_thr(0);
    occupancy = 4'd1; step(1); occupancy = 4'd0; step(1);
    chk("R8 sticky", irq_status[0], 1);
    clr(2'b10);
    chk("R8 zero mask keeps", irq_status[0], 1);
    clr(2'b01);
    chk("R8 cleared", irq_status[0], 0);
    occupancy = 4'd1; clr(2'b01);
    chk("R8 set wins", irq_status[0], 1);

    // R9 enable gating
    chk("R9 no enable", irq, 0);
    wr_en(2'b01); chk("R9 count enabled", irq, 1);
    wr_en(2'b10); chk("R9 timeout only", irq, 0);
    wr_en(2'b11); chk("R9 both", irq, 1);
    occupancy = 4'd0; step(1); clr(2'b11);
    chk("R9 cleared", irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule